// File: doc/BRIEF.md
# Bicubic Patch Culling Unit

This unit sits in front of a hardware tessellator. For each bicubic surface patch it decides whether the whole patch can be dropped before any tessellation begins. A patch enters in a single valid/ready beat. The beat carries the 16 homogeneous control points of the patch, a fixed set of clipping planes, up to a fixed number of precomputed convex-hull faces (each face is a vertex triple), the eye position and the number of faces in use. The unit then runs two tests in sequence and returns one decision beat.

The first test is trivial rejection. The planes are visited one per cycle. For the current plane, all 16 points are evaluated in parallel, which gives a 16-bit outside mask. If that mask is full, the patch is rejected at once. When no plane rejects the patch, the hull faces are visited one per cycle. The first face that points toward the eye ends the search with a keep decision. If no face points toward the eye, the patch is discarded as back-facing. Because each point carries its weight as the fourth coordinate, rational patches go through the same path.

Top module: `patch_cull`

## Requirements
- R1: `in_ready` is high only while the unit is idle. A patch is accepted on a clock edge where `in_valid` and `in_ready` are both high. No further patch is accepted until the decision beat has been taken with `out_ready`, and `in_ready` returns high on the edge that follows.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_code` keeps its value.
- R3: The decision code is 2'b01 (clipped) when all 16 points are outside the same plane. Point k = row*4+col sits at `pts_i[(k*4+c)*CW +: CW]`, with c = 0..3 for x, y, z, w. Plane p sits at `planes_i[(p*4+c)*CW +: CW]`, with coefficients a, b, c, d. A point is outside when a*x+b*y+c*z+d*w is strictly positive.
- R4: If some points are outside one plane and the rest are outside a different plane, with no single plane holding all 16, the patch is not clipped.
- R5: A point whose plane product is exactly zero is not outside.
- R6: The weight w enters the plane product. Points with the same x, y, z can be clipped at one weight and kept at another.
- R7: Planes are checked first, one per cycle. A patch first clipped by plane p gets its decision `out_valid` p+1 cycles after acceptance, with code 01, whatever its faces are.
- R8: Face f occupies `faces_i[(f*9+v*3+c)*CW +: CW]`, with v = 0..2 and c = x, y, z. The eye sits at `eye_i[c*CW +: CW]`. A face points toward the eye when the dot product of (v1-v0)x(v2-v0) with (eye-v0) is strictly positive. The first such face, at index f, gives code 2'b00 (keep) NPLANES+1+f cycles after acceptance, and the later faces are not examined.
- R9: With `nfaces_i` = N ≥ 1 and no face pointing toward the eye, the code is 2'b10 (back-facing), NPLANES+N cycles after acceptance. A face with a zero product counts as not facing the eye.
- R10: With `nfaces_i` = 0 and no clipping plane, the code is 2'b10 after NPLANES cycles.
- R11: `out_code` is never 2'b11 while `out_valid` is high.
- R12: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Patch beat offered |
| in_ready | output | 1 | Unit idle, beat can be taken |
| pts_i | input | 64*CW | 16 homogeneous control points |
| planes_i | input | NPLANES*4*CW | Plane coefficients a, b, c, d |
| faces_i | input | MAXF*9*CW | Hull faces as vertex triples |
| eye_i | input | 3*CW | Eye position x, y, z |
| nfaces_i | input | clog2(MAXF+1) | Faces in use, clamped to MAXF |
| out_valid | output | 1 | Decision beat present |
| out_ready | input | 1 | Decision consumed |
| out_code | output | 2 | 00 keep, 01 clipped, 10 back-facing |

## Verification
The hardest behaviour to see from the ports is the early exit. The unit must stop at the first face that points toward the eye and never look at the faces after it. The code alone cannot show this, because a keep decision looks the same whichever face caused it. The stimulus therefore places forward faces at a known position, with further forward faces after them, and measures the cycles from acceptance to `out_valid`. The count exposes exactly which face ended the search. Plane precedence is checked the same way: a patch that has a forward face but is clipped by its third plane must answer after three cycles with the clipped code.

// File: rtl/patch_cull.sv
module patch_cull #(
  parameter int CW      = 16,
  parameter int NPLANES = 6,
  parameter int MAXF    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [64*CW-1:0]          pts_i,
  input  logic [NPLANES*4*CW-1:0]   planes_i,
  input  logic [MAXF*9*CW-1:0]      faces_i,
  input  logic [3*CW-1:0]           eye_i,
  input  logic [$clog2(MAXF+1)-1:0] nfaces_i,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [1:0]                out_code
);
  localparam int NFW = $clog2(MAXF+1);
  localparam int PIW = (NPLANES > 1) ? $clog2(NPLANES) : 1;
  localparam int PW  = 2*CW + 2;
  localparam int FW  = 3*CW + 6;

  typedef enum logic [1:0] {S_IDLE, S_PLANE, S_FACE, S_DONE} state_t;

  function automatic logic signed [PW-1:0] sxp(input logic [CW-1:0] a);
    return {{(PW-CW){a[CW-1]}}, a};
  endfunction
  function automatic logic signed [FW-1:0] sxf(input logic [CW-1:0] a);
    return {{(FW-CW){a[CW-1]}}, a};
  endfunction

  state_t                    state;
  logic [64*CW-1:0]          pt_q;
  logic [NPLANES*4*CW-1:0]   pl_q;
  logic [MAXF*9*CW-1:0]      fc_q;
  logic [3*CW-1:0]           eye_q;
  logic [NFW-1:0]            nf_q;
  logic [PIW-1:0]            pidx;
  logic [NFW-1:0]            fidx;
  logic [1:0]                code_q;

  assign in_ready  = (state == S_IDLE);
  assign out_valid = (state == S_DONE);
  assign out_code  = code_q;

  logic [4*CW-1:0]       pl_sel;
  logic signed [PW-1:0]  pa, pb, pc, pd;
  logic [15:0]           out_mask;

  assign pl_sel = pl_q[pidx*4*CW +: 4*CW];
  assign pa = sxp(pl_sel[0*CW +: CW]);
  assign pb = sxp(pl_sel[1*CW +: CW]);
  assign pc = sxp(pl_sel[2*CW +: CW]);
  assign pd = sxp(pl_sel[3*CW +: CW]);

  for (genvar k = 0; k < 16; k++) begin : g_pt
    logic signed [PW-1:0] dot;
    assign dot = sxp(pt_q[(k*4+0)*CW +: CW]) * pa
               + sxp(pt_q[(k*4+1)*CW +: CW]) * pb
               + sxp(pt_q[(k*4+2)*CW +: CW]) * pc
               + sxp(pt_q[(k*4+3)*CW +: CW]) * pd;
    assign out_mask[k] = !dot[PW-1] && (|dot);
  end

  logic [9*CW-1:0]       f_sel;
  logic signed [FW-1:0]  v [9];
  logic signed [FW-1:0]  e1x, e1y, e1z, e2x, e2y, e2z;
  logic signed [FW-1:0]  nx, ny, nz, tx, ty, tz, fdot;
  logic                  fwd;

  assign f_sel = fc_q[fidx*9*CW +: 9*CW];
  for (genvar i = 0; i < 9; i++) begin : g_v
    assign v[i] = sxf(f_sel[i*CW +: CW]);
  end

  assign e1x = v[3] - v[0];
  assign e1y = v[4] - v[1];
  assign e1z = v[5] - v[2];
  assign e2x = v[6] - v[0];
  assign e2y = v[7] - v[1];
  assign e2z = v[8] - v[2];
  assign nx  = e1y*e2z - e1z*e2y;
  assign ny  = e1z*e2x - e1x*e2z;
  assign nz  = e1x*e2y - e1y*e2x;
  assign tx  = sxf(eye_q[0*CW +: CW]) - v[0];
  assign ty  = sxf(eye_q[1*CW +: CW]) - v[1];
  assign tz  = sxf(eye_q[2*CW +: CW]) - v[2];
  assign fdot = nx*tx + ny*ty + nz*tz;
  assign fwd  = !fdot[FW-1] && (|fdot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pidx   <= '0;
      fidx   <= '0;
      code_q <= 2'b00;
      nf_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          pt_q  <= pts_i;
          pl_q  <= planes_i;
          fc_q  <= faces_i;
          eye_q <= eye_i;
          nf_q  <= (nfaces_i > NFW'(MAXF)) ? NFW'(MAXF) : nfaces_i;
          pidx  <= '0;
          state <= S_PLANE;
        end
        S_PLANE: begin
          if (&out_mask) begin
            code_q <= 2'b01;
            state  <= S_DONE;
          end else if (pidx == PIW'(NPLANES-1)) begin
            fidx <= '0;
            if (nf_q == '0) begin
              code_q <= 2'b10;
              state  <= S_DONE;
            end else begin
              state <= S_FACE;
            end
          end else begin
            pidx <= pidx + PIW'(1);
          end
        end
        S_FACE: begin
          if (fwd) begin
            code_q <= 2'b00;
            state  <= S_DONE;
          end else if (fidx == nf_q - NFW'(1)) begin
            code_q <= 2'b10;
            state  <= S_DONE;
          end else begin
            fidx <= fidx + NFW'(1);
          end
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module patch_cull_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_code
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code));
  assert_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_code != 2'b11);
  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
  assert_return_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);
  assert_reopen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(out_valid && out_ready));
endmodule

bind patch_cull patch_cull_chk u_chk (.*);

// File: tb/test_patch_cull.sv
module test_patch_cull;
  localparam int CW = 16, NP = 6, MF = 8, NFW = $clog2(MF+1);

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic in_ready, out_valid;
  logic [1:0] out_code;
  logic [64*CW-1:0] pts = '0;
  logic [NP*4*CW-1:0] pl = '0;
  logic [MF*9*CW-1:0] fc = '0;
  logic [3*CW-1:0] eye = '0;
  logic [NFW-1:0] nf = '0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  patch_cull #(.CW(CW), .NPLANES(NP), .MAXF(MF)) i_patch_cull (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pts_i(pts), .planes_i(pl), .faces_i(fc), .eye_i(eye), .nfaces_i(nf),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_pt(input int k, input int x, input int y, input int z, input int w);
    pts[(k*4+0)*CW +: CW] = CW'(x);
    pts[(k*4+1)*CW +: CW] = CW'(y);
    pts[(k*4+2)*CW +: CW] = CW'(z);
    pts[(k*4+3)*CW +: CW] = CW'(w);
  endtask

  task automatic set_all(input int x, input int y, input int z, input int w);
    for (int k = 0; k < 16; k++) set_pt(k, x, y, z, w);
  endtask

  task automatic set_pl(input int p, input int a, input int b, input int c, input int d);
    pl[(p*4+0)*CW +: CW] = CW'(a);
    pl[(p*4+1)*CW +: CW] = CW'(b);
    pl[(p*4+2)*CW +: CW] = CW'(c);
    pl[(p*4+3)*CW +: CW] = CW'(d);
  endtask

  task automatic set_v(input int f, input int vi, input int x, input int y, input int z);
    fc[(f*9+vi*3+0)*CW +: CW] = CW'(x);
    fc[(f*9+vi*3+1)*CW +: CW] = CW'(y);
    fc[(f*9+vi*3+2)*CW +: CW] = CW'(z);
  endtask

  // kind 0: faces eye at +z, 1: faces away, 2: degenerate
  task automatic set_face(input int f, input int kind);
    set_v(f, 0, 0, 0, 0);
    if (kind == 0) begin set_v(f, 1, 1, 0, 0); set_v(f, 2, 0, 1, 0); end
    else if (kind == 1) begin set_v(f, 1, 0, 1, 0); set_v(f, 2, 1, 0, 0); end
    else begin set_v(f, 1, 1, 0, 0); set_v(f, 2, 1, 0, 0); end
  endtask

  task automatic base();
    pl = '0; fc = '0; set_all(0, 0, 0, 1);
    eye = '0; eye[2*CW +: CW] = CW'(100);
  endtask

  task automatic run(input int n, input int exp_code, input int exp_lat, input string tag);
    int cnt = 0;
    nf = NFW'(n);
    @(negedge clk);
    chk(in_ready, {tag, " idle"}, in_ready, 1);
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    while (!out_valid && cnt < 100) begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    chk(out_valid && out_code == 2'(exp_code), {tag, " code"}, out_code, exp_code);
    chk(cnt == exp_lat, {tag, " latency"}, cnt, exp_lat);
  endtask

  task automatic consume();
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 0;
    chk(in_ready && !out_valid, "R1 reopen", in_ready, 1);
  endtask

  task automatic t_reset();
    chk(in_ready == 1, "R12 in_ready", in_ready, 1);
    chk(out_valid == 0, "R12 out_valid", out_valid, 0);
  endtask

  task automatic t_clip();
    base(); set_pl(2, 1, 0, 0, -10); set_all(20, 0, 0, 1); set_face(0, 0);
    run(1, 1, 3, "R3 R7 clip plane 2");
    consume();
  endtask

  task automatic t_spread();
    base(); set_pl(0, 1, 0, 0, -10); set_pl(1, 0, 1, 0, -10);
    for (int k = 0; k < 8; k++) set_pt(k, 20, 0, 0, 1);
    for (int k = 8; k < 16; k++) set_pt(k, 0, 20, 0, 1);
    set_face(0, 0);
    run(1, 0, NP + 1, "R4 spread");
    consume();
  endtask

  task automatic t_boundary();
    base(); set_pl(0, 1, 0, 0, -10); set_all(10, 0, 0, 1); set_face(0, 0);
    run(1, 0, NP + 1, "R5 on plane");
    consume();
  endtask

  task automatic t_weight();
    base(); set_pl(3, 1, 0, 0, -10); set_face(0, 0);
    set_all(20, 5, 5, 3);
    run(1, 0, NP + 1, "R6 w=3 kept");
    consume();
    set_all(20, 5, 5, 1);
    run(1, 1, 4, "R6 w=1 clipped");
    consume();
  endtask

  task automatic t_early();
    base();
    set_face(0, 1); set_face(1, 2); set_face(2, 0); set_face(3, 1); set_face(4, 0);
    run(5, 0, NP + 3, "R8 first fwd face 2");
    consume();
    set_face(0, 0);
    run(5, 0, NP + 1, "R8 first fwd face 0");
    consume();
  endtask

  task automatic t_back();
    base();
    for (int f = 0; f < MF; f++) set_face(f, 1);
    run(MF, 2, NP + MF, "R9 all back");
    consume();
    set_face(0, 2);
    run(1, 2, NP + 1, "R9 degenerate");
    consume();
    run(0, 2, NP, "R10 zero faces");
    consume();
  endtask

  task automatic t_wide();
    base();
    set_pl(5, 32767, 0, 0, -32768); set_all(30000, 0, 0, 1);
    run(0, 1, 6, "R3 wide clip");
    consume();
    pl = '0;
    eye[0 +: CW] = CW'(0); eye[CW +: CW] = CW'(0); eye[2*CW +: CW] = CW'(32767);
    set_v(0, 0, -32768, -32768, 0); set_v(0, 1, 32767, -32768, 0); set_v(0, 2, -32768, 32767, 0);
    set_v(1, 0, -32768, -32768, 0); set_v(1, 1, -32768, 32767, 0); set_v(1, 2, 32767, -32768, 0);
    run(2, 0, NP + 1, "R8 wide fwd");
    consume();
    set_v(0, 1, -32768, 32767, 0); set_v(0, 2, 32767, -32768, 0);
    run(2, 2, NP + 2, "R9 wide back");
    consume();
  endtask

  task automatic t_hold();
    base(); set_pl(0, 1, 0, 0, -10); set_all(20, 0, 0, 1);
    run(0, 1, 1, "R7 clip plane 0");
    in_valid = 1;
    set_pl(0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid && out_code == 2'b01, "R2 hold", out_code, 1);
      chk(!in_ready, "R1 busy", in_ready, 0);
    end
    in_valid = 0;
    consume();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clip();
    t_spread();
    t_boundary();
    t_weight();
    t_early();
    t_back();
    t_wide();
    t_hold();
    summary();
  end
endmodule